// File: doc/BRIEF.md
# Write-once special mode register

This block holds the three power-up policy bits of a power-management controller: a development mode that relaxes supervision, an error-pin emulation mode, and a limp-home policy for fail-safe entry. Software reaches it with 16-bit command words that an upstream serial shifter has already deserialized. Each command addressed to this register returns one of two feedback words. It may also update the stored policy bits. An update takes effect at most once per power cycle, and only while the controller is still in start-up and no mode-register write has happened yet.

The stored bits drive two outputs. The enable pin either follows its normal request or reports whether a 4-bit CAN failure diagnostic is clean. On each fail-safe entry, a one-cycle pulse tells the configuration logic to set or to clear its IC bit. The development bit is special in two ways. A high-voltage test-pin condition can force it on at power-up, and the mode-register logic can clear it at any time.

Top module: `wocfg_smr`

## Requirements
- R1: After the power-on reset is released, all three policy bits read 0, `rd_valid_o` is 0, `ic_set_o`/`ic_clr_o` are 0, and `en_o` follows `en_req_i`.
- R2: A command is taken only when `cmd_valid_i` is 1 and bits 15:14 equal binary 01. Any other address produces no readback and changes no bit.
- R3: One cycle after a taken command, `rd_valid_o` is 1 for exactly one cycle. `rd_data_o` then carries `ien_fb_i` if bit 13 was 0, or `int_fb_i` if bit 13 was 1.
- R4: A taken command with bit 12 = 1 is a pure read and leaves the policy bits unchanged.
- R5: An accepted write (bit 12 = 0) stores bit 9 as development mode, bit 8 as error-pin emulation and bit 7 as limp-home policy. It takes effect on the next cycle, and the reserved bits 11, 10 and 6:0 have no effect.
- R6: Only the first accepted write after power-on takes effect. Later writes change nothing until the next power-on reset.
- R7: A write is rejected while `startup_i` is 0. A rejected write still produces its readback.
- R8: A pulse on `mode_wr_i`, in the same cycle or earlier, locks out every later write.
- R9: If `test_hv_i` is 1 on the first clock edge after reset release, development mode is set.
- R10: A `dev_clr_i` pulse clears development mode on the next cycle, whatever the lock state. It wins over a write in the same cycle, but the other bits of that write are still stored.
- R11: With error-pin emulation set, `en_o` is 1 when `canfd_i` equals 0000 and 0 otherwise. With it cleared, `en_o` equals `en_req_i`.
- R12: One cycle after `fs_entry_i`, `ic_set_o` pulses if limp-home is 1, and `ic_clr_o` pulses if it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 16 | Deserialized command word |
| startup_i | input | 1 | Controller is in start-up mode |
| mode_wr_i | input | 1 | Mode register write strobe |
| dev_clr_i | input | 1 | Clear request for development mode |
| test_hv_i | input | 1 | High-voltage test-pin condition |
| ien_fb_i | input | FB_W | Interrupt-enable feedback word |
| int_fb_i | input | FB_W | Interrupt feedback word |
| canfd_i | input | DIAG_W | CAN failure diagnostic |
| en_req_i | input | 1 | Normal enable request |
| fs_entry_i | input | 1 | Fail-safe entry strobe |
| dev_mode_o | output | 1 | Development mode bit |
| err_emul_o | output | 1 | Error-pin emulation bit |
| limp_home_o | output | 1 | Limp-home policy bit |
| en_o | output | 1 | Enable pin |
| rd_valid_o | output | 1 | Readback valid |
| rd_data_o | output | FB_W | Readback data |
| ic_set_o | output | 1 | Set IC bit pulse |
| ic_clr_o | output | 1 | Clear IC bit pulse |

## Verification
A write lock that is wrongly clear shows up the cycle after a second write, as a policy bit that changes. A lock that is wrongly set shows up as a first write that never reaches the bit outputs. A wrong error-emulation bit shows at `en_o` at once, without waiting for an edge. A wrong limp-home bit shows only when fail-safe is entered, so the bench pulses `fs_entry_i` in both states and checks which pulse appears one cycle later. A bad readback select shows as the wrong feedback word on the next cycle.

// File: rtl/wocfg_pkg.sv
package wocfg_pkg;
    localparam int CMD_W      = 16;
    localparam int ADDR_HI    = 15;
    localparam int ADDR_LO    = 14;
    localparam int SEL_BIT    = 13;
    localparam int RO_BIT     = 12;
    localparam int DEV_BIT    = 9;
    localparam int ERRE_BIT   = 8;
    localparam int LHM_BIT    = 7;
    localparam logic [1:0] MY_ADDR = 2'b01;

    typedef struct packed {
        logic dev;
        logic erre;
        logic lhm;
    } cfg_t;

    typedef struct packed {
        logic hit;
        logic sel_int;
        logic wr_req;
        cfg_t wr_cfg;
    } cmd_t;
endpackage

// File: rtl/wocfg_decode.sv
module wocfg_decode
    import wocfg_pkg::*;
(
    input  logic             valid_i,
    input  logic [CMD_W-1:0] word_i,
    output cmd_t             cmd_o
);
    always_comb begin
        cmd_o.hit         = valid_i && (word_i[ADDR_HI:ADDR_LO] == MY_ADDR);
        cmd_o.sel_int     = word_i[SEL_BIT];
        cmd_o.wr_req      = cmd_o.hit && !word_i[RO_BIT];
        cmd_o.wr_cfg.dev  = word_i[DEV_BIT];
        cmd_o.wr_cfg.erre = word_i[ERRE_BIT];
        cmd_o.wr_cfg.lhm  = word_i[LHM_BIT];
    end
endmodule

// File: rtl/wocfg_state.sv
module wocfg_state
    import wocfg_pkg::*;
#(
    parameter int FB_W = 16
) (
    input  logic            clk,
    input  logic            por_n,
    input  cmd_t            cmd_i,
    input  logic            startup_i,
    input  logic            mode_wr_i,
    input  logic            dev_clr_i,
    input  logic            test_hv_i,
    input  logic            fs_entry_i,
    input  logic [FB_W-1:0] ien_fb_i,
    input  logic [FB_W-1:0] int_fb_i,
    output cfg_t            cfg_o,
    output logic            rd_valid_o,
    output logic [FB_W-1:0] rd_data_o,
    output logic            ic_set_o,
    output logic            ic_clr_o
);
    typedef struct packed {
        logic            boot;
        logic            lock;
        cfg_t            cfg;
        logic            rd_valid;
        logic [FB_W-1:0] rd_data;
        logic            ic_set;
        logic            ic_clr;
    } state_t;

    state_t st_d, st_q;
    logic   wr_ok;

    always_comb begin
        st_d          = st_q;
        st_d.boot     = 1'b0;
        wr_ok         = cmd_i.wr_req && startup_i && !st_q.lock && !mode_wr_i;
        if (st_q.boot && test_hv_i) begin
            st_d.cfg.dev = 1'b1;
        end
        if (wr_ok) begin
            st_d.cfg  = cmd_i.wr_cfg;
        end
        if (wr_ok || mode_wr_i) begin
            st_d.lock = 1'b1;
        end
        if (dev_clr_i) begin
            st_d.cfg.dev = 1'b0;
        end
        st_d.rd_valid = cmd_i.hit;
        if (cmd_i.hit) begin
            st_d.rd_data = cmd_i.sel_int ? int_fb_i : ien_fb_i;
        end
        st_d.ic_set   = fs_entry_i && st_q.cfg.lhm;
        st_d.ic_clr   = fs_entry_i && !st_q.cfg.lhm;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q      <= '0;
            st_q.boot <= 1'b1;
        end else begin
            st_q      <= st_d;
        end
    end

    assign cfg_o      = st_q.cfg;
    assign rd_valid_o = st_q.rd_valid;
    assign rd_data_o  = st_q.rd_data;
    assign ic_set_o   = st_q.ic_set;
    assign ic_clr_o   = st_q.ic_clr;

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        st_q.lock |=> st_q.lock);
    assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!por_n)
        st_q.lock |=> ($stable(cfg_o.erre) && $stable(cfg_o.lhm)));
    assert_no_write_outside_startup_R7: assert property (@(posedge clk) disable iff (!por_n)
        (!startup_i && !st_q.boot) |=> ($stable(cfg_o.erre) && $stable(cfg_o.lhm)));
    assert_mode_wr_locks_R8: assert property (@(posedge clk) disable iff (!por_n)
        mode_wr_i |=> st_q.lock);
    assert_readback_follows_R3: assert property (@(posedge clk) disable iff (!por_n)
        cmd_i.hit |=> rd_valid_o);
    assert_dev_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
        dev_clr_i |=> !cfg_o.dev);
    assert_ic_pulse_R12: assert property (@(posedge clk) disable iff (!por_n)
        fs_entry_i |=> (ic_set_o == $past(cfg_o.lhm)) && (ic_clr_o != $past(cfg_o.lhm)));
    assert_ic_onehot_R12: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({ic_set_o, ic_clr_o}));
endmodule

// File: rtl/wocfg_pinmux.sv
module wocfg_pinmux #(
    parameter int DIAG_W = 4
) (
    input  logic              erre_i,
    input  logic [DIAG_W-1:0] canfd_i,
    input  logic              en_req_i,
    output logic              en_o
);
    logic diag_clean;

    always_comb begin
        diag_clean = (canfd_i == '0);
        en_o       = erre_i ? diag_clean : en_req_i;
    end

    always_comb begin
        if (erre_i === 1'b1 && $countones(canfd_i) > 0) begin
            assert_en_emul_fault_R11: assert (en_o == 1'b0);
        end
    end
endmodule

// File: rtl/wocfg_smr.sv
module wocfg_smr
    import wocfg_pkg::*;
#(
    parameter int FB_W   = 16,
    parameter int DIAG_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cmd_valid_i,
    input  logic [15:0]       cmd_word_i,
    input  logic              startup_i,
    input  logic              mode_wr_i,
    input  logic              dev_clr_i,
    input  logic              test_hv_i,
    input  logic [FB_W-1:0]   ien_fb_i,
    input  logic [FB_W-1:0]   int_fb_i,
    input  logic [DIAG_W-1:0] canfd_i,
    input  logic              en_req_i,
    input  logic              fs_entry_i,
    output logic              dev_mode_o,
    output logic              err_emul_o,
    output logic              limp_home_o,
    output logic              en_o,
    output logic              rd_valid_o,
    output logic [FB_W-1:0]   rd_data_o,
    output logic              ic_set_o,
    output logic              ic_clr_o
);
    cmd_t cmd;
    cfg_t cfg;

    wocfg_decode u_decode (
        .valid_i (cmd_valid_i),
        .word_i  (cmd_word_i),
        .cmd_o   (cmd)
    );

    wocfg_state #(.FB_W(FB_W)) u_state (
        .clk        (clk),
        .por_n      (por_n),
        .cmd_i      (cmd),
        .startup_i  (startup_i),
        .mode_wr_i  (mode_wr_i),
        .dev_clr_i  (dev_clr_i),
        .test_hv_i  (test_hv_i),
        .fs_entry_i (fs_entry_i),
        .ien_fb_i   (ien_fb_i),
        .int_fb_i   (int_fb_i),
        .cfg_o      (cfg),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .ic_set_o   (ic_set_o),
        .ic_clr_o   (ic_clr_o)
    );

    wocfg_pinmux #(.DIAG_W(DIAG_W)) u_pinmux (
        .erre_i   (cfg.erre),
        .canfd_i  (canfd_i),
        .en_req_i (en_req_i),
        .en_o     (en_o)
    );

    assign dev_mode_o  = cfg.dev;
    assign err_emul_o  = cfg.erre;
    assign limp_home_o = cfg.lhm;
endmodule

// File: tb/tb_wocfg_smr.sv
module tb_wocfg_smr;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [15:0] cmd_word_i = '0;
    logic        startup_i = 1'b0, mode_wr_i = 1'b0, dev_clr_i = 1'b0, test_hv_i = 1'b0;
    logic [15:0] ien_fb_i = 16'hA5C3, int_fb_i = 16'h3C5A;
    logic [3:0]  canfd_i = '0;
    logic        en_req_i = 1'b0, fs_entry_i = 1'b0;
    logic        dev_mode_o, err_emul_o, limp_home_o, en_o, rd_valid_o, ic_set_o, ic_clr_o;
    logic [15:0] rd_data_o;

    int checks = 0, fails = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    wocfg_smr dut (.*);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_chk(string req, logic d, logic e, logic l);
        chk(req, {13'd0, dev_mode_o, err_emul_o, limp_home_o}, {13'd0, d, e, l});
    endtask

    task automatic send(logic [15:0] w);
        @(negedge clk);
        cmd_word_i  = w;
        cmd_valid_i = 1'b1;
        if (w[15:14] == 2'b01) exp_q.push_back(w[13] ? int_fb_i : ien_fb_i);
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic power_up(logic hv);
        @(negedge clk);
        por_n = 1'b0;
        test_hv_i = hv;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        test_hv_i = 1'b0;
    endtask

    // monitor: pops expected readback items
    always @(negedge clk) begin
        if (por_n && rd_valid_o) begin
            if (exp_q.size() == 0) chk("R2 unexpected readback", 16'h1, 16'h0);
            else chk("R3 readback data", rd_data_o, exp_q.pop_front());
        end
    end

    initial begin
        #2000000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        power_up(1'b0);
        cfg_chk("R1 reset cfg", 0, 0, 0);
        chk("R1 rd_valid", {15'd0, rd_valid_o}, 16'd0);
        chk("R1 ic pulses", {14'd0, ic_set_o, ic_clr_o}, 16'd0);
        en_req_i = 1'b1; #1;
        chk("R1 en follows request", {15'd0, en_o}, 16'd1);
        en_req_i = 1'b0; #1;
        chk("R1 en follows request low", {15'd0, en_o}, 16'd0);

        startup_i = 1'b1;
        send(16'h8380);
        cfg_chk("R2 wrong address ignored", 0, 0, 0);
        startup_i = 1'b0;
        send(16'h4380);
        cfg_chk("R7 write outside startup", 0, 0, 0);
        startup_i = 1'b1;
        send(16'h5380);
        cfg_chk("R4 read-only command", 0, 0, 0);
        send(16'h7380);
        send(16'h4FFF);
        cfg_chk("R5 accepted write", 1, 1, 1);

        canfd_i = 4'h0; en_req_i = 1'b0; #1;
        chk("R11 emulation clean", {15'd0, en_o}, 16'd1);
        canfd_i = 4'h5; en_req_i = 1'b1; #1;
        chk("R11 emulation fault", {15'd0, en_o}, 16'd0);

        pulse(fs_entry_i);
        chk("R12 limp-home set pulse", {14'd0, ic_set_o, ic_clr_o}, 16'b10);
        @(negedge clk);
        chk("R12 pulse one cycle", {14'd0, ic_set_o, ic_clr_o}, 16'b00);

        send(16'h4000);
        cfg_chk("R6 second write ignored", 1, 1, 1);
        pulse(dev_clr_i);
        cfg_chk("R10 clear while locked", 0, 1, 1);

        power_up(1'b1);
        cfg_chk("R9 test pin sets dev", 1, 0, 0);
        pulse(mode_wr_i);
        send(16'h4180);
        cfg_chk("R8 write after mode write", 1, 0, 0);
        canfd_i = 4'h3; en_req_i = 1'b1; #1;
        chk("R11 normal enable", {15'd0, en_o}, 16'd1);
        pulse(fs_entry_i);
        chk("R12 limp-home clear pulse", {14'd0, ic_set_o, ic_clr_o}, 16'b01);

        power_up(1'b0);
        @(negedge clk);
        cmd_word_i = 16'h4380; cmd_valid_i = 1'b1; mode_wr_i = 1'b1;
        exp_q.push_back(ien_fb_i);
        @(negedge clk);
        cmd_valid_i = 1'b0; mode_wr_i = 1'b0;
        cfg_chk("R8 same-cycle mode write", 0, 0, 0);

        power_up(1'b0);
        @(negedge clk);
        cmd_word_i = 16'h4380; cmd_valid_i = 1'b1; dev_clr_i = 1'b1;
        exp_q.push_back(ien_fb_i);
        @(negedge clk);
        cmd_valid_i = 1'b0; dev_clr_i = 1'b0;
        cfg_chk("R10 clear wins over write", 0, 1, 1);

        repeat (3) @(negedge clk);
        chk("R3 all readbacks seen", 16'(exp_q.size()), 16'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule